// File: doc/BRIEF.md
# Exception Request Priority Controller

This block sits next to a small CPU sequencer and decides which exception the sequencer takes, and on which clock. It receives a synchronous sample of the active-low reset pin and a one-cycle watchdog overflow pulse. It also receives the trace flag, a level interrupt request with a 7-bit vector, and a trap strobe with a 2-bit trap number. From the sequencer it receives an instruction-end strobe, an exception-sequence-done strobe, two flags that classify the instruction that just ended, and the 2-bit interrupt control mode.

At most one exception is granted per clock. A grant raises a one-clock take pulse and drives a registered exception kind and vector number. The controller then stays busy until the sequencer reports that the exception sequence is over. Reset and watchdog overflow act at once. Trace and interrupt are only considered at a boundary. A boundary is an instruction end while the controller is idle, or the end of an exception sequence while it is busy. A trap is taken whenever the controller is idle.

Top module: `exc_arbiter`

## Requirements
- R1: While `res_pin_n` is sampled low, from the following clock on `rst_hold` is 1, `exc_kind` is 1 (reset), `exc_vec` is 0 and `take_exc` is 0. Every other request is discarded.
- R2: At the first clock edge that samples `res_pin_n` high after reset, `take_exc` rises for exactly one clock with kind 1 and vector 0, and `rst_hold` falls.
- R3: A watchdog pulse sampled with `res_pin_n` high gives a take of kind 1, vector 0 at that edge. It overrides every other request, even while the controller is busy.
- R4: After any take the controller is busy. While busy, instruction ends and trap strobes grant nothing until `seq_done` is sampled.
- R5: Trace and interrupt are granted only at a boundary. A boundary is `insn_end` while idle, or `seq_done` while busy. A request held between boundaries grants nothing.
- R6: Trace is granted only when `icmode` equals 2. It then has kind 2 and vector 5. In any other mode the trace flag is ignored.
- R7: Trace is not granted at an instruction end where `cls_rte` is 1. At an exception-sequence boundary, `cls_rte` has no effect.
- R8: An interrupt has kind 3 and vector equal to `irq_vec`, zero-extended to 8 bits. It is not granted at an instruction end where `cls_flagmod` is 1. If `irq_req` is still high, it is granted at the next eligible boundary.
- R9: An interrupt is not granted at the boundary that ends the reset exception sequence, whether that sequence came from the pin or from the watchdog.
- R10: A trap strobe sampled while idle is granted with no boundary needed. It has kind 4 and vector 8 plus `trap_num`.
- R11: When several requests are eligible on one clock, the priority is watchdog/reset, then trace, then interrupt, then trap. A losing trap strobe is not kept.
- R12: `exc_kind` and `exc_vec` keep the last granted value until the next grant. Kind 0 means nothing has been granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_pin_n | input | 1 | Synchronised reset pin sample, active low |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| trace_flag | input | 1 | Trace bit from the status register |
| irq_req | input | 1 | Pending interrupt request (level) |
| irq_vec | input | 7 | Interrupt vector number from the requester |
| trap_stb | input | 1 | Trap instruction executed |
| trap_num | input | 2 | Trap number of that instruction |
| insn_end | input | 1 | Instruction-end strobe |
| seq_done | input | 1 | Exception sequence finished |
| cls_rte | input | 1 | Ending instruction is a return-from-exception |
| cls_flagmod | input | 1 | Ending instruction writes the control/condition register |
| icmode | input | 2 | Interrupt control mode |
| take_exc | output | 1 | One-clock take-exception pulse |
| exc_kind | output | 3 | Granted kind: 0 none, 1 reset, 2 trace, 3 interrupt, 4 trap |
| exc_vec | output | 8 | Granted vector number |
| rst_hold | output | 1 | Holds the sequencer in reset handling |

## Verification
From the idle state, every combination of mode, trace flag, interrupt request, the two instruction-class flags, trap strobe and instruction-end strobe is applied. This separates the mode gate, the two blocking rules, the boundary rule and the priority order from one another. Directed sequences cover the rest. They hold an interrupt across non-boundary clocks and across a blocked boundary, which separates pending behaviour from edge capture. They send requests while busy and during reset. They raise the watchdog during a busy sequence, and check that interrupts are blocked after both kinds of reset. A trace is presented at an exception-sequence boundary with `cls_rte` set, which shows that the class flags apply only at instruction ends.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_RESET = 3'd1,
        EXC_TRACE = 3'd2,
        EXC_IRQ   = 3'd3,
        EXC_TRAP  = 3'd4
    } exc_kind_e;

    localparam int unsigned KIND_W = 3;

endpackage

// File: rtl/exc_gate.sv
// Boundary detection and per-source eligibility filtering.
module exc_gate #(
    parameter int unsigned MODE_W     = 2,
    parameter int unsigned TRACE_MODE = 2
) (
    input  logic              busy,
    input  logic              post_rst,
    input  logic              insn_end,
    input  logic              seq_done,
    input  logic              cls_rte,
    input  logic              cls_flagmod,
    input  logic [MODE_W-1:0] icmode,
    input  logic              trace_flag,
    input  logic              irq_req,
    input  logic              trap_stb,
    output logic              boundary,
    output logic              trace_ok,
    output logic              irq_ok,
    output logic              trap_ok
);
    logic insn_path;
    logic mode_match;

    always_comb begin
        insn_path  = !busy;
        boundary   = busy ? seq_done : insn_end;
        mode_match = (icmode == MODE_W'(TRACE_MODE));
        trace_ok   = boundary && trace_flag && mode_match
                     && !(insn_path && cls_rte);
        irq_ok     = boundary && irq_req && !post_rst
                     && !(insn_path && cls_flagmod);
        trap_ok    = insn_path && trap_stb;
    end

endmodule

// File: rtl/exc_pick.sv
// Fixed-priority selection among eligible sources and vector formation.
module exc_pick
    import exc_pkg::*;
#(
    parameter int unsigned VEC_W        = 8,
    parameter int unsigned IRQ_VEC_W    = 7,
    parameter int unsigned TRAP_NUM_W   = 2,
    parameter int unsigned TRACE_VECTOR = 5,
    parameter int unsigned TRAP_BASE    = 8
) (
    input  logic                  trace_ok,
    input  logic                  irq_ok,
    input  logic                  trap_ok,
    input  logic [IRQ_VEC_W-1:0]  irq_vec,
    input  logic [TRAP_NUM_W-1:0] trap_num,
    output logic                  pick_valid,
    output exc_kind_e             pick_kind,
    output logic [VEC_W-1:0]      pick_vec
);
    logic [VEC_W-1:0] irq_vec_ext;
    logic [VEC_W-1:0] trap_vec;

    generate
        if (IRQ_VEC_W < VEC_W) begin : g_irq_widen
            assign irq_vec_ext = {{(VEC_W-IRQ_VEC_W){1'b0}}, irq_vec};
        end else begin : g_irq_fit
            assign irq_vec_ext = irq_vec[VEC_W-1:0];
        end
    endgenerate

    assign trap_vec = VEC_W'(TRAP_BASE) + VEC_W'(trap_num);

    always_comb begin
        pick_valid = 1'b1;
        pick_kind  = EXC_NONE;
        pick_vec   = '0;
        if (trace_ok) begin
            pick_kind = EXC_TRACE;
            pick_vec  = VEC_W'(TRACE_VECTOR);
        end else if (irq_ok) begin
            pick_kind = EXC_IRQ;
            pick_vec  = irq_vec_ext;
        end else if (trap_ok) begin
            pick_kind = EXC_TRAP;
            pick_vec  = trap_vec;
        end else begin
            pick_valid = 1'b0;
        end
    end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int unsigned VEC_W        = 8,
    parameter int unsigned IRQ_VEC_W    = 7,
    parameter int unsigned TRAP_NUM_W   = 2,
    parameter int unsigned MODE_W       = 2,
    parameter int unsigned TRACE_MODE   = 2,
    parameter int unsigned TRACE_VECTOR = 5,
    parameter int unsigned TRAP_BASE    = 8
) (
    input  logic                  clk,
    input  logic                  res_pin_n,
    input  logic                  wdt_ovf,
    input  logic                  trace_flag,
    input  logic                  irq_req,
    input  logic [IRQ_VEC_W-1:0]  irq_vec,
    input  logic                  trap_stb,
    input  logic [TRAP_NUM_W-1:0] trap_num,
    input  logic                  insn_end,
    input  logic                  seq_done,
    input  logic                  cls_rte,
    input  logic                  cls_flagmod,
    input  logic [MODE_W-1:0]     icmode,
    output logic                  take_exc,
    output logic [KIND_W-1:0]     exc_kind,
    output logic [VEC_W-1:0]      exc_vec,
    output logic                  rst_hold
);
    typedef struct packed {
        logic             in_reset;
        logic             busy;
        logic             post_rst;
        logic             take;
        exc_kind_e        kind;
        logic [VEC_W-1:0] vec;
    } arb_state_t;

    localparam arb_state_t RESET_STATE = '{
        in_reset: 1'b1, busy: 1'b0, post_rst: 1'b1, take: 1'b0,
        kind: EXC_RESET, vec: '0
    };

    arb_state_t st_q, st_d;

    logic             boundary;
    logic             trace_ok, irq_ok, trap_ok;
    logic             pick_valid;
    exc_kind_e        pick_kind;
    logic [VEC_W-1:0] pick_vec;

    exc_gate #(
        .MODE_W     (MODE_W),
        .TRACE_MODE (TRACE_MODE)
    ) u_gate (
        .busy        (st_q.busy),
        .post_rst    (st_q.post_rst),
        .insn_end    (insn_end),
        .seq_done    (seq_done),
        .cls_rte     (cls_rte),
        .cls_flagmod (cls_flagmod),
        .icmode      (icmode),
        .trace_flag  (trace_flag),
        .irq_req     (irq_req),
        .trap_stb    (trap_stb),
        .boundary    (boundary),
        .trace_ok    (trace_ok),
        .irq_ok      (irq_ok),
        .trap_ok     (trap_ok)
    );

    exc_pick #(
        .VEC_W        (VEC_W),
        .IRQ_VEC_W    (IRQ_VEC_W),
        .TRAP_NUM_W   (TRAP_NUM_W),
        .TRACE_VECTOR (TRACE_VECTOR),
        .TRAP_BASE    (TRAP_BASE)
    ) u_pick (
        .trace_ok   (trace_ok),
        .irq_ok     (irq_ok),
        .trap_ok    (trap_ok),
        .irq_vec    (irq_vec),
        .trap_num   (trap_num),
        .pick_valid (pick_valid),
        .pick_kind  (pick_kind),
        .pick_vec   (pick_vec)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        // The sequence-end boundary consumes the post-reset interrupt block.
        if (st_q.busy && seq_done) begin
            st_d.busy     = 1'b0;
            st_d.post_rst = 1'b0;
        end
        if (st_q.in_reset || wdt_ovf) begin
            st_d.in_reset = 1'b0;
            st_d.busy     = 1'b1;
            st_d.post_rst = 1'b1;
            st_d.take     = 1'b1;
            st_d.kind     = EXC_RESET;
            st_d.vec      = '0;
        end else if (pick_valid) begin
            st_d.busy = 1'b1;
            st_d.take = 1'b1;
            st_d.kind = pick_kind;
            st_d.vec  = pick_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!res_pin_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_exc = st_q.take;
    assign exc_kind = st_q.kind;
    assign exc_vec  = st_q.vec;
    assign rst_hold = st_q.in_reset;

endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk
    import exc_pkg::*;
#(
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned TRAP_NUM_W = 2,
    parameter int unsigned MODE_W     = 2,
    parameter int unsigned TRACE_MODE = 2,
    parameter int unsigned TRAP_BASE  = 8
) (
    input logic                  clk,
    input logic                  res_pin_n,
    input logic                  wdt_ovf,
    input logic                  insn_end,
    input logic                  seq_done,
    input logic [MODE_W-1:0]     icmode,
    input logic [TRAP_NUM_W-1:0] trap_num,
    input logic                  take_exc,
    input logic [KIND_W-1:0]     exc_kind,
    input logic [VEC_W-1:0]      exc_vec,
    input logic                  rst_hold
);
    p_hold_shows_reset_r1: assert property (@(posedge clk) disable iff (!res_pin_n)
        rst_hold |-> (exc_kind == EXC_RESET) && !take_exc);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!res_pin_n)
        take_exc && !wdt_ovf && !seq_done |=> !take_exc);

    p_wdt_takes_reset_r3: assert property (@(posedge clk) disable iff (!res_pin_n)
        wdt_ovf |=> take_exc && (exc_kind == EXC_RESET) && (exc_vec == '0));

    p_irq_at_boundary_r5: assert property (@(posedge clk) disable iff (!res_pin_n)
        take_exc && (exc_kind == EXC_IRQ) |-> $past(insn_end || seq_done));

    p_trace_mode_r6: assert property (@(posedge clk) disable iff (!res_pin_n)
        take_exc && (exc_kind == EXC_TRACE) |-> $past(icmode) == MODE_W'(TRACE_MODE));

    p_trap_vector_r10: assert property (@(posedge clk) disable iff (!res_pin_n)
        take_exc && (exc_kind == EXC_TRAP)
        |-> exc_vec == VEC_W'(TRAP_BASE) + VEC_W'($past(trap_num)));

endmodule

bind exc_arbiter exc_arbiter_chk #(
    .VEC_W      (VEC_W),
    .TRAP_NUM_W (TRAP_NUM_W),
    .MODE_W     (MODE_W),
    .TRACE_MODE (TRACE_MODE),
    .TRAP_BASE  (TRAP_BASE)
) u_exc_chk (
    .clk       (clk),
    .res_pin_n (res_pin_n),
    .wdt_ovf   (wdt_ovf),
    .insn_end  (insn_end),
    .seq_done  (seq_done),
    .icmode    (icmode),
    .trap_num  (trap_num),
    .take_exc  (take_exc),
    .exc_kind  (exc_kind),
    .exc_vec   (exc_vec),
    .rst_hold  (rst_hold)
);

// File: tb/test_exc_arbiter.sv
`timescale 1ns/1ps
module test_exc_arbiter;
    logic       clk = 1'b0;
    logic       res_pin_n, wdt_ovf, trace_flag, irq_req, trap_stb;
    logic [6:0] irq_vec;
    logic [1:0] trap_num, icmode;
    logic       insn_end, seq_done, cls_rte, cls_flagmod;
    logic       take_exc, rst_hold;
    logic [2:0] exc_kind;
    logic [7:0] exc_vec;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    exc_arbiter i_exc_arbiter (
        .clk(clk), .res_pin_n(res_pin_n), .wdt_ovf(wdt_ovf),
        .trace_flag(trace_flag), .irq_req(irq_req), .irq_vec(irq_vec),
        .trap_stb(trap_stb), .trap_num(trap_num), .insn_end(insn_end),
        .seq_done(seq_done), .cls_rte(cls_rte), .cls_flagmod(cls_flagmod),
        .icmode(icmode), .take_exc(take_exc), .exc_kind(exc_kind),
        .exc_vec(exc_vec), .rst_hold(rst_hold)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        wdt_ovf = 0; trace_flag = 0; irq_req = 0; trap_stb = 0;
        insn_end = 0; seq_done = 0; cls_rte = 0; cls_flagmod = 0;
    endtask

    // Advance one edge; inputs change and outputs are read 1 ns after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_take(input string tag, input int kind, input int vec);
        chk({tag, " take"}, take_exc, 1);
        chk({tag, " kind"}, exc_kind, kind);
        chk({tag, " vec"},  exc_vec,  vec);
    endtask

    // Close any open exception sequence with nothing else pending.
    task automatic finish_seq();
        quiet(); seq_done = 1; step(); quiet();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        quiet(); res_pin_n = 0; irq_vec = 7'd0; trap_num = 0; icmode = 2;
        step(); step();
        // R1: reset held, requests discarded
        irq_req = 1; trap_stb = 1; wdt_ovf = 1; insn_end = 1; trace_flag = 1;
        step();
        chk("R1 hold", rst_hold, 1);
        chk("R1 kind", exc_kind, 1);
        chk("R1 vec", exc_vec, 0);
        chk("R1 take", take_exc, 0);
        quiet();
        // R2: release
        res_pin_n = 1; step();
        expect_take("R2 release", 1, 0);
        chk("R2 hold", rst_hold, 0);
        // R4: busy ignores insn_end and trap
        irq_req = 1; irq_vec = 7'd33; insn_end = 1; trap_stb = 1; step();
        chk("R2 one pulse", take_exc, 0);
        step();
        chk("R4 busy no take", take_exc, 0);
        // R9: boundary ending reset blocks interrupt
        insn_end = 0; trap_stb = 0; seq_done = 1; step();
        chk("R9 post-reset irq blocked", take_exc, 0);
        seq_done = 0;
        // R5: request between boundaries grants nothing
        step(); step();
        chk("R5 no boundary", take_exc, 0);
        // R8: still-pending interrupt granted at next boundary
        insn_end = 1; step();
        expect_take("R8 pending", 3, 33);
        // R12: value held
        quiet(); step();
        chk("R12 kind held", exc_kind, 3);
        chk("R12 vec held", exc_vec, 33);
        finish_seq();

        // Sweep at idle: mode, trace, irq, rte, flagmod, trap, insn_end
        for (int i = 0; i < 256; i++) begin
            int m, tr, ir, rte, fm, tp, ie, ek, ev;
            m = i & 3; tr = (i >> 2) & 1; ir = (i >> 3) & 1; rte = (i >> 4) & 1;
            fm = (i >> 5) & 1; tp = (i >> 6) & 1; ie = (i >> 7) & 1;
            icmode = 2'(m); trace_flag = tr[0]; irq_req = ir[0]; cls_rte = rte[0];
            cls_flagmod = fm[0]; trap_stb = tp[0]; insn_end = ie[0];
            irq_vec = 7'((i * 13 + 7) % 128); trap_num = 2'(i % 4);
            ek = 0; ev = 0;
            if (ie == 1 && tr == 1 && m == 2 && rte == 0) begin ek = 2; ev = 5; end
            else if (ie == 1 && ir == 1 && fm == 0) begin ek = 3; ev = (i * 13 + 7) % 128; end
            else if (tp == 1) begin ek = 4; ev = 8 + (i % 4); end
            step();
            if (ek == 0) chk("R5 R6 R7 R8 sweep idle", take_exc, 0);
            else if (ek == 2) expect_take("R6 R7 R11 sweep trace", ek, ev);
            else if (ek == 3) expect_take("R8 R11 sweep irq", ek, ev);
            else expect_take("R10 R11 sweep trap", ek, ev);
            quiet();
            if (ek != 0) finish_seq();
        end

        // R7: cls_rte ignored at exception-sequence boundary
        icmode = 2; trap_stb = 1; trap_num = 3; step();
        expect_take("R10 trap", 4, 11);
        quiet(); trace_flag = 1; cls_rte = 1; seq_done = 1; step();
        expect_take("R7 trace at seq end", 2, 5);
        quiet();
        // R3: watchdog while busy
        wdt_ovf = 1; trace_flag = 1; step();
        expect_take("R3 wdt busy", 1, 0);
        quiet();
        irq_req = 1; irq_vec = 7'd99; seq_done = 1; step();
        chk("R9 after wdt irq blocked", take_exc, 0);
        seq_done = 0; insn_end = 1; step();
        expect_take("R8 after wdt", 3, 99);
        quiet(); finish_seq();
        // R3 R11: watchdog beats trace at a boundary
        trace_flag = 1; insn_end = 1; wdt_ovf = 1; step();
        expect_take("R3 R11 wdt over trace", 1, 0);
        quiet(); finish_seq();
        // R11: lost trap not retained
        trace_flag = 1; insn_end = 1; trap_stb = 1; trap_num = 1; step();
        expect_take("R11 trace over trap", 2, 5);
        quiet(); finish_seq(); step();
        chk("R11 trap dropped", take_exc, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule